// File: doc/BRIEF.md
# Time-Division Crossbar Cell Scheduler

This block drives the select lines of an N×N cell crossbar and the dequeue strobes of the per-flow input queues. Packets arrive already cut into equal-size cells, and each input keeps one queue per flow. A frame holds M cell-times. For every output and every slot of the frame, a table names the input and the flow to serve. On each cell-time strobe the block reads the entry of the current slot for every output. It then checks the occupancy flag of the named queue and, one clock later, issues a crossbar select and a one-clock dequeue pulse. A flow needing C cells per P cell-times is given enough slots per frame to cover that rate. For example, 3 cells per 11 cell-times is served with 2 slots in a 5-slot frame.

The table is loaded through a simple write port into a shadow copy. The shadow copy becomes active only when the slot counter wraps from the last slot to slot 0, so a frame is never served from a half-written schedule. Each write is checked against the shadow copy. Any write that would let two outputs take the same input in one slot is refused, and so is any write whose fields are out of range. A refused write raises an error pulse. Because of this check, every slot is always a matching. An empty scheduled queue leaves its output idle for that slot, and the slot is not handed to anyone else.

Top module: `tdma_xbar_sched`

## Requirements
- R1: While `rst_n` is low at a clock edge, the edge clears the slot counter to 0, clears both tables to all-invalid and drives `xbar_vld`, `xbar_sel`, `deq` and `cfg_err` to zero.
- R2: Each clock edge with `cell_tick` high advances `cur_slot` by one, and slot M-1 wraps to 0. An edge with `cell_tick` low leaves `cur_slot` unchanged.
- R3: On an edge with `cell_tick` high, take each output o whose active entry for the current slot is valid and names input i and flow f, with queue flag bit `q_nonempty[i*N_FLOWS+f]` set. For the next clock only, such an output has `xbar_vld[o]`=1, `xbar_sel[o*IW +: IW]`=i and `deq[i*N_FLOWS+f]`=1. Every other output has `xbar_vld` 0 and select 0. All outputs are zero after an edge without `cell_tick`.
- R4: If the scheduled queue is empty, the output idles for that slot. No other queue is dequeued in its place, even when another flow of the same input holds data.
- R5: In any clock, at most one `deq` bit per input is set, and no two valid outputs carry the same select value.
- R6: Table writes go to the shadow copy. The shadow copy becomes active on the `cell_tick` edge that wraps slot M-1 to 0. A write presented on that same edge reaches the active table only at the following wrap.
- R7: A write with `cfg_vld`=1 is refused if another output already holds a valid shadow entry with the same input in the same slot. A write with `cfg_slot` ≥ M, an input ≥ N or a flow ≥ N_FLOWS is also refused. A refused write leaves the table unchanged and sets `cfg_err` for the clock after the write; an accepted write leaves `cfg_err` low.
- R8: A write with `cfg_vld`=0 clears the entry, which frees its input for other outputs in that slot.
- R9: One input may serve the same output from different flows in different slots. Each slot dequeues only the flow its own entry names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cell_tick | input | 1 | One-clock strobe marking a cell-time |
| q_nonempty | input | N_PORTS*N_FLOWS | Occupancy flag per queue, bit i*N_FLOWS+f |
| cfg_we | input | 1 | Table write strobe |
| cfg_out | input | IW | Output addressed by the write |
| cfg_slot | input | SW | Slot addressed by the write |
| cfg_vld | input | 1 | 1 assigns the entry, 0 clears it |
| cfg_in | input | IW | Input to serve |
| cfg_flow | input | FW | Flow of that input to serve |
| cfg_err | output | 1 | One-clock pulse: the previous write was refused |
| cur_slot | output | SW | Slot the next cell-time will serve |
| xbar_vld | output | N_PORTS | Output o receives a cell this clock |
| xbar_sel | output | N_PORTS*IW | Input selected for each output |
| deq | output | N_PORTS*N_FLOWS | One-clock dequeue pulse per queue |

## Verification
A corrupted slot counter shows up on the first cell-time after the fault: the select pattern of a different slot appears, and `cur_slot` disagrees with the count of ticks. A corrupted active or shadow entry shows up as a wrong select or dequeue bit in its own slot, within one frame of the fault or within one frame of the next wrap. A missed or early shadow swap shows up during the first frame after the wrap, as the old or the new pattern appearing one frame too soon or too late. A failed conflict check shows up at once as a missing `cfg_err` pulse, and one frame later as two outputs sharing an input.

// File: rtl/tdma_xbar_pkg.sv
// Package: shared helpers for the time-division crossbar scheduler.
// Assumes: widths are derived from counts that are at least 1.
package tdma_xbar_pkg;
    // Index width for a count, never below one bit.
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/tdma_slot_ctr.sv
// Module: frame slot counter. Advances on each cell-time strobe and wraps
// from M_SLOTS-1 to 0; flags the wrapping strobe for the table swap.
// Assumes: cell_tick is a single-clock strobe.
module tdma_slot_ctr #(
    parameter int M_SLOTS = 5,
    localparam int SW = tdma_xbar_pkg::idx_w(M_SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cell_tick,
    output logic [SW-1:0] slot,
    output logic          wrap
);
    localparam logic [SW-1:0] LAST = SW'(M_SLOTS - 1);

    // Strobe that ends a frame.
    assign wrap = cell_tick && (slot == LAST);

    // Slot register: step on tick, wrap at end of frame.
    always_ff @(posedge clk) begin
        if (!rst_n)         slot <= '0;
        else if (wrap)      slot <= '0;
        else if (cell_tick) slot <= slot + 1'b1;
    end

    a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_tick && slot == LAST) |=> (slot == '0));
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cell_tick |=> $stable(slot));
endmodule

// File: rtl/tdma_sched_table.sv
// Module: schedule storage. A shadow table takes checked writes; the active
// table is copied from it on the frame wrap and read for the current slot.
// Assumes: rd_slot is always below M_SLOTS.
module tdma_sched_table #(
    parameter int N_PORTS = 4,
    parameter int N_FLOWS = 2,
    parameter int M_SLOTS = 5,
    localparam int IW = tdma_xbar_pkg::idx_w(N_PORTS),
    localparam int FW = tdma_xbar_pkg::idx_w(N_FLOWS),
    localparam int SW = tdma_xbar_pkg::idx_w(M_SLOTS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  swap,
    input  logic                  cfg_we,
    input  logic [IW-1:0]         cfg_out,
    input  logic [SW-1:0]         cfg_slot,
    input  logic                  cfg_vld,
    input  logic [IW-1:0]         cfg_in,
    input  logic [FW-1:0]         cfg_flow,
    output logic                  cfg_err,
    input  logic [SW-1:0]         rd_slot,
    output logic [N_PORTS-1:0]    rd_vld,
    output logic [N_PORTS*IW-1:0] rd_in,
    output logic [N_PORTS*FW-1:0] rd_flow
);
    logic          sh_vld [N_PORTS][M_SLOTS];
    logic [IW-1:0] sh_in  [N_PORTS][M_SLOTS];
    logic [FW-1:0] sh_fl  [N_PORTS][M_SLOTS];
    logic          ac_vld [N_PORTS][M_SLOTS];
    logic [IW-1:0] ac_in  [N_PORTS][M_SLOTS];
    logic [FW-1:0] ac_fl  [N_PORTS][M_SLOTS];

    int   wo, ws;
    logic in_range, clash, accept;

    // Decode the write address and its range.
    always_comb begin
        wo       = int'(cfg_out);
        ws       = (int'(cfg_slot) < M_SLOTS) ? int'(cfg_slot) : 0;
        in_range = (int'(cfg_out) < N_PORTS) && (int'(cfg_slot) < M_SLOTS) &&
                   (int'(cfg_in) < N_PORTS) && (int'(cfg_flow) < N_FLOWS);
    end

    // Look for another output already taking the same input in that slot.
    always_comb begin
        clash = 1'b0;
        for (int o = 0; o < N_PORTS; o++)
            if (o != wo && cfg_vld && sh_vld[o][ws] && sh_in[o][ws] == cfg_in)
                clash = 1'b1;
        accept = in_range && !clash;
    end

    // Shadow writes, frame-boundary copy and error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int o = 0; o < N_PORTS; o++)
                for (int s = 0; s < M_SLOTS; s++) begin
                    sh_vld[o][s] <= 1'b0;
                    sh_in[o][s]  <= '0;
                    sh_fl[o][s]  <= '0;
                    ac_vld[o][s] <= 1'b0;
                    ac_in[o][s]  <= '0;
                    ac_fl[o][s]  <= '0;
                end
            cfg_err <= 1'b0;
        end else begin
            cfg_err <= cfg_we && !accept;
            if (cfg_we && accept) begin
                sh_vld[wo][ws] <= cfg_vld;
                sh_in[wo][ws]  <= cfg_in;
                sh_fl[wo][ws]  <= cfg_flow;
            end
            if (swap) begin
                ac_vld <= sh_vld;
                ac_in  <= sh_in;
                ac_fl  <= sh_fl;
            end
        end
    end

    // Read the active entries of every output for the current slot.
    always_comb begin
        for (int o = 0; o < N_PORTS; o++) begin
            rd_vld[o]           = ac_vld[o][int'(rd_slot)];
            rd_in[o*IW +: IW]   = ac_in[o][int'(rd_slot)];
            rd_flow[o*FW +: FW] = ac_fl[o][int'(rd_slot)];
        end
    end

    a_r7_err_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> $past(cfg_we));
endmodule

// File: rtl/tdma_issue.sv
// Module: per-cell-time issue stage. Turns the current slot's entries and the
// queue flags into registered crossbar selects and dequeue pulses.
// Assumes: entries name inputs and flows in range and form a matching.
module tdma_issue #(
    parameter int N_PORTS = 4,
    parameter int N_FLOWS = 2,
    localparam int IW = tdma_xbar_pkg::idx_w(N_PORTS),
    localparam int FW = tdma_xbar_pkg::idx_w(N_FLOWS),
    localparam int NQ = N_PORTS * N_FLOWS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cell_tick,
    input  logic [N_PORTS-1:0]    ent_vld,
    input  logic [N_PORTS*IW-1:0] ent_in,
    input  logic [N_PORTS*FW-1:0] ent_flow,
    input  logic [NQ-1:0]         q_nonempty,
    output logic [N_PORTS-1:0]    xbar_vld,
    output logic [N_PORTS*IW-1:0] xbar_sel,
    output logic [NQ-1:0]         deq
);
    logic [N_PORTS-1:0]    hit;
    logic [N_PORTS*IW-1:0] sel_n;
    logic [NQ-1:0]         deq_n;

    // Serve each output only from the queue its entry names.
    always_comb begin
        hit   = '0;
        sel_n = '0;
        deq_n = '0;
        for (int o = 0; o < N_PORTS; o++) begin
            int q;
            q = int'(ent_in[o*IW +: IW]) * N_FLOWS + int'(ent_flow[o*FW +: FW]);
            if (ent_vld[o] && q < NQ && q_nonempty[q]) begin
                hit[o]            = 1'b1;
                sel_n[o*IW +: IW] = ent_in[o*IW +: IW];
                deq_n[q]          = 1'b1;
            end
        end
    end

    // Register the decisions for exactly one clock per cell-time.
    always_ff @(posedge clk) begin
        if (!rst_n || !cell_tick) begin
            xbar_vld <= '0;
            xbar_sel <= '0;
            deq      <= '0;
        end else begin
            xbar_vld <= hit;
            xbar_sel <= sel_n;
            deq      <= deq_n;
        end
    end

    a_r3_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        !cell_tick |=> (xbar_vld == '0 && deq == '0));

    for (genvar i = 0; i < N_PORTS; i++) begin : g_in
        a_r5_one_deq_per_input: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(deq[i*N_FLOWS +: N_FLOWS]));
    end

    for (genvar q = 0; q < NQ; q++) begin : g_q
        a_r4_deq_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
            deq[q] |-> $past(q_nonempty[q]));
    end

    for (genvar a = 0; a < N_PORTS; a++) begin : g_pa
        for (genvar b = a + 1; b < N_PORTS; b++) begin : g_pb
            a_r5_distinct_sel: assert property (@(posedge clk) disable iff (!rst_n)
                !(xbar_vld[a] && xbar_vld[b] &&
                  xbar_sel[a*IW +: IW] == xbar_sel[b*IW +: IW]));
        end
    end
endmodule

// File: rtl/tdma_xbar_sched.sv
// Module: top of the time-division crossbar scheduler. Ties the slot counter,
// the double-buffered schedule table and the issue stage together.
// Assumes: queue flags are valid at each cell_tick edge.
module tdma_xbar_sched #(
    parameter int N_PORTS = 4,
    parameter int N_FLOWS = 2,
    parameter int M_SLOTS = 5,
    localparam int IW = tdma_xbar_pkg::idx_w(N_PORTS),
    localparam int FW = tdma_xbar_pkg::idx_w(N_FLOWS),
    localparam int SW = tdma_xbar_pkg::idx_w(M_SLOTS),
    localparam int NQ = N_PORTS * N_FLOWS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cell_tick,
    input  logic [NQ-1:0]         q_nonempty,
    input  logic                  cfg_we,
    input  logic [IW-1:0]         cfg_out,
    input  logic [SW-1:0]         cfg_slot,
    input  logic                  cfg_vld,
    input  logic [IW-1:0]         cfg_in,
    input  logic [FW-1:0]         cfg_flow,
    output logic                  cfg_err,
    output logic [SW-1:0]         cur_slot,
    output logic [N_PORTS-1:0]    xbar_vld,
    output logic [N_PORTS*IW-1:0] xbar_sel,
    output logic [NQ-1:0]         deq
);
    logic                  wrap;
    logic [N_PORTS-1:0]    ent_vld;
    logic [N_PORTS*IW-1:0] ent_in;
    logic [N_PORTS*FW-1:0] ent_flow;

    tdma_slot_ctr #(.M_SLOTS(M_SLOTS)) u_ctr (
        .clk(clk), .rst_n(rst_n), .cell_tick(cell_tick),
        .slot(cur_slot), .wrap(wrap)
    );

    tdma_sched_table #(.N_PORTS(N_PORTS), .N_FLOWS(N_FLOWS), .M_SLOTS(M_SLOTS)) u_tbl (
        .clk(clk), .rst_n(rst_n), .swap(wrap),
        .cfg_we(cfg_we), .cfg_out(cfg_out), .cfg_slot(cfg_slot),
        .cfg_vld(cfg_vld), .cfg_in(cfg_in), .cfg_flow(cfg_flow),
        .cfg_err(cfg_err), .rd_slot(cur_slot),
        .rd_vld(ent_vld), .rd_in(ent_in), .rd_flow(ent_flow)
    );

    tdma_issue #(.N_PORTS(N_PORTS), .N_FLOWS(N_FLOWS)) u_iss (
        .clk(clk), .rst_n(rst_n), .cell_tick(cell_tick),
        .ent_vld(ent_vld), .ent_in(ent_in), .ent_flow(ent_flow),
        .q_nonempty(q_nonempty),
        .xbar_vld(xbar_vld), .xbar_sel(xbar_sel), .deq(deq)
    );

    a_r3_deq_with_vld: assert property (@(posedge clk) disable iff (!rst_n)
        (deq != '0) |-> (xbar_vld != '0));
endmodule

// File: tb/tb_tdma_xbar_sched.sv
// Bench: vector walk over two frames, then directed reset, refusal and
// frame-boundary tests. N=4 ports, 2 flows, 5 slots; queue index = in*2+flow.
module tb_tdma_xbar_sched;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cell_tick = 1'b0;
    logic [7:0] q_ne = '0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_out = '0;
    logic [2:0] cfg_slot = '0;
    logic       cfg_vld = 1'b0;
    logic [1:0] cfg_in = '0;
    logic       cfg_flow = 1'b0;
    logic       cfg_err;
    logic [2:0] cur_slot;
    logic [3:0] xbar_vld;
    logic [7:0] xbar_sel;
    logic [7:0] deq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tdma_xbar_sched dut (
        .clk(clk), .rst_n(rst_n), .cell_tick(cell_tick), .q_nonempty(q_ne),
        .cfg_we(cfg_we), .cfg_out(cfg_out), .cfg_slot(cfg_slot), .cfg_vld(cfg_vld),
        .cfg_in(cfg_in), .cfg_flow(cfg_flow), .cfg_err(cfg_err), .cur_slot(cur_slot),
        .xbar_vld(xbar_vld), .xbar_sel(xbar_sel), .deq(deq)
    );

    // {tick, q_nonempty, exp vld, exp sel, exp deq, exp slot after}
    localparam logic [31:0] VEC [12] = '{
        {1'b1, 8'hFF, 4'b0011, 8'h01, 8'h06, 3'd1},
        {1'b1, 8'hFF, 4'b0101, 8'h31, 8'h48, 3'd2},
        {1'b1, 8'hFF, 4'b1000, 8'h80, 8'h20, 3'd3},
        {1'b0, 8'hFF, 4'b0000, 8'h00, 8'h00, 3'd3},
        {1'b1, 8'hFF, 4'b0000, 8'h00, 8'h00, 3'd4},
        {1'b1, 8'hFF, 4'b1110, 8'h48, 8'h19, 3'd0},
        {1'b1, 8'h05, 4'b0001, 8'h01, 8'h04, 3'd1},
        {1'b1, 8'h04, 4'b0000, 8'h00, 8'h00, 3'd2},
        {1'b1, 8'h20, 4'b1000, 8'h80, 8'h20, 3'd3},
        {1'b1, 8'hFF, 4'b0000, 8'h00, 8'h00, 3'd4},
        {1'b1, 8'h09, 4'b1100, 8'h40, 8'h09, 3'd0},
        {1'b1, 8'h00, 4'b0000, 8'h00, 8'h00, 3'd1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic t, input logic [7:0] q);
        cell_tick = t;
        q_ne = q;
        @(negedge clk);
        cell_tick = 1'b0;
    endtask

    task automatic wr(input logic [1:0] o, input logic [2:0] s, input logic v,
                      input logic [1:0] i, input logic f);
        cfg_out = o; cfg_slot = s; cfg_vld = v; cfg_in = i; cfg_flow = f;
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic outs(input string tag, input logic [3:0] v, input logic [7:0] s,
                        input logic [7:0] d);
        chk({tag, " vld"}, 32'(xbar_vld), 32'(v));
        chk({tag, " sel"}, 32'(xbar_sel), 32'(s));
        chk({tag, " deq"}, 32'(deq), 32'(d));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 slot", 32'(cur_slot), 0);
        outs("R1", 4'h0, 8'h00, 8'h00);
        chk("R1 cfg_err", 32'(cfg_err), 0);

        // Program the schedule; each write must be accepted (R7).
        wr(2'd0, 3'd0, 1'b1, 2'd1, 1'b0);
        wr(2'd1, 3'd0, 1'b1, 2'd0, 1'b1);
        wr(2'd0, 3'd1, 1'b1, 2'd1, 1'b1);
        wr(2'd2, 3'd1, 1'b1, 2'd3, 1'b0);
        wr(2'd3, 3'd2, 1'b1, 2'd2, 1'b1);
        wr(2'd1, 3'd4, 1'b1, 2'd2, 1'b0);
        wr(2'd2, 3'd4, 1'b1, 2'd0, 1'b0);
        wr(2'd3, 3'd4, 1'b1, 2'd1, 1'b1);
        chk("R7 accepted write", 32'(cfg_err), 0);

        // R6: writes not active until the wrap; first frame stays idle.
        step(1'b1, 8'hFF);
        outs("R6 before swap", 4'h0, 8'h00, 8'h00);
        for (int k = 0; k < 4; k++) step(1'b1, 8'hFF);
        chk("R2 wrap", 32'(cur_slot), 0);

        // Vector walk: R3/R4/R9 per slot, R2 hold on the no-tick vector.
        for (int k = 0; k < 12; k++) begin
            logic [31:0] v;
            v = VEC[k];
            step(v[31], v[30:23]);
            outs($sformatf("R3 R4 R9 vec %0d", k), v[22:19], v[18:11], v[10:3]);
            chk($sformatf("R2 vec %0d slot", k), 32'(cur_slot), 32'(v[2:0]));
        end
        // Slot now 1; run to slot 0.
        for (int k = 0; k < 4; k++) step(1'b1, 8'h00);

        // R7: clash with o0 on input 1 in slot 0, then out-of-range slot.
        wr(2'd2, 3'd0, 1'b1, 2'd1, 1'b1);
        chk("R7 clash refused", 32'(cfg_err), 1);
        @(negedge clk);
        chk("R7 err is one pulse", 32'(cfg_err), 0);
        wr(2'd2, 3'd5, 1'b1, 2'd2, 1'b0);
        chk("R7 slot range refused", 32'(cfg_err), 1);
        // R8: clear o0 slot0, then input 1 is free for o2.
        wr(2'd0, 3'd0, 1'b0, 2'd0, 1'b0);
        wr(2'd2, 3'd0, 1'b1, 2'd1, 1'b0);
        chk("R8 freed input accepted", 32'(cfg_err), 0);

        // R6: old table still serves slot 0 of this frame.
        step(1'b1, 8'hFF);
        outs("R6 old table", 4'b0011, 8'h01, 8'h06);
        for (int k = 0; k < 4; k++) step(1'b1, 8'hFF);
        step(1'b1, 8'hFF);
        outs("R8 new slot0", 4'b0110, 8'h10, 8'h06);

        // R6: write on the wrap edge lands one frame later.
        for (int k = 0; k < 3; k++) step(1'b1, 8'h00);
        chk("R2 at slot 4", 32'(cur_slot), 4);
        cfg_out = 2'd0; cfg_slot = 3'd1; cfg_vld = 1'b0; cfg_in = 2'd0; cfg_flow = 1'b0;
        cfg_we = 1'b1;
        step(1'b1, 8'h00);
        cfg_we = 1'b0;
        step(1'b1, 8'h00);
        step(1'b1, 8'hFF);
        outs("R6 wrap write deferred", 4'b0101, 8'h31, 8'h48);
        for (int k = 0; k < 4; k++) step(1'b1, 8'h00);
        step(1'b1, 8'hFF);
        outs("R6 wrap write applied", 4'b0100, 8'h30, 8'h40);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule